// File: doc/BRIEF.md
# Block Address Translation Array

This block holds a small file of block-translation entries. Each entry maps one large, naturally aligned region of the 32-bit effective address space directly onto a physical region of the same size. The entries are split into an instruction-side group and a data-side group. Software programs each entry as two 32-bit words through a plain indexed write port and can read any word back on a combinational read port.

A lookup presents an effective address, an instruction/data select, the privilege level and a write flag. One clock later the block reports whether an entry hit, the translated physical address, the four cache attribute bits of the hitting entry and a protection-fault verdict. The region size of each entry comes from a contiguous-ones length mask. Validity is qualified separately for supervisor and user accesses.

Top module: `bat_array`

## Requirements
- R1: After reset every stored word reads back as zero. A write with `wr_en` stores `wr_data` into the word picked by `wr_idx` and `wr_hi` (1 = tag word, 0 = data word). `rd_data` shows the stored word picked by `rd_idx`/`rd_hi` in the same cycle.
- R2: Entries 0 to N_PER_SIDE-1 are instruction-side. Bit 3 (guarded) of their data word is always stored as 0 and reads back as 0. Data-side entries keep that bit as written.
- R3: Tag word layout: bits 31:17 hold the effective block index, bits 12:2 hold the length mask, bit 1 is supervisor-valid and bit 0 is user-valid. Effective address bits 31:17 are compared with the index only where the mask bit is 0. The 11 mask bits align with address bits 27:17, so mask 0x000 covers 128 KB, 0x001 covers 256 KB, and so on up to 0x7FF for 256 MB.
- R4: On a hit, physical address bits 16:0 equal the effective address bits. Bits 31:17 take the stored physical block index (data word bits 31:17) where the mask bit is 0 and the effective address bit where it is 1.
- R5: An entry can hit only if its valid bit for the current privilege is set: bit 1 when `lk_sup` is 1, bit 0 when it is 0.
- R6: A lookup with `lk_inst`=1 considers only instruction-side entries. A lookup with `lk_inst`=0 considers only data-side entries (indices N_PER_SIDE to 2*N_PER_SIDE-1).
- R7: If several entries hit, the lowest-numbered one supplies the address, attributes and verdict.
- R8: The protection field is data word bits 1:0, where 00 means no access, 01 read only, 10 read/write and 11 read only. A hitting write faults unless the field is 10. A hitting read faults only when the field is 00.
- R9: On a hit, `res_attr` is data word bits 6:3, ordered write-through, cache-inhibit, coherence, guarded (guarded at bit 0). On a miss or an idle cycle, `res_hit`, `res_pa`, `res_attr` and `res_fault` are all zero.
- R10: Results are registered. `res_valid` and the result fields appear on the clock edge after the edge that sampled `lk_valid`, and they are computed from the entry contents as they stood before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Entry word write strobe |
| wr_idx | input | 3 | Entry index to write |
| wr_hi | input | 1 | 1 selects tag word, 0 selects data word |
| wr_data | input | 32 | Word to store |
| rd_idx | input | 3 | Entry index to read |
| rd_hi | input | 1 | 1 selects tag word, 0 selects data word |
| rd_data | output | 32 | Stored word, combinational |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address |
| lk_inst | input | 1 | 1 instruction side, 0 data side |
| lk_sup | input | 1 | 1 supervisor, 0 user |
| lk_write | input | 1 | 1 for a write access |
| res_valid | output | 1 | Result valid, one cycle after request |
| res_hit | output | 1 | An entry matched |
| res_pa | output | 32 | Physical address |
| res_attr | output | 4 | Write-through, inhibit, coherence, guarded |
| res_fault | output | 1 | Protection violation |

## Verification
The readback port is combinational, so `rd_data` is due in the cycle its selects change and reflects a write only after the edge that performs it. Lookup results take exactly one register stage. Inputs change just after a rising edge, and the behavioural reference model captures its expected result at the same rising edge as the design. Every output is then compared at the following falling edge, so each result is checked in the cycle it is due, with no slack allowed.

// File: rtl/bat_pkg.sv
package bat_pkg;
   // Bit positions inside the data word that neighbouring logic decodes
   localparam int ATTR_LSB  = 3;
   localparam int ATTR_W    = 4;
   localparam int GUARD_BIT = 3;
   localparam int PROT_W    = 2;

   typedef enum logic [PROT_W-1:0] {
      PROT_NONE = 2'b00,
      PROT_RO   = 2'b01,
      PROT_RW   = 2'b10,
      PROT_RO2  = 2'b11
   } prot_e;

   function automatic logic prot_violation(input logic [PROT_W-1:0] p, input logic is_wr);
      if (is_wr) return (p != PROT_RW);
      return (p == PROT_NONE);
   endfunction
endpackage

// File: rtl/bat_store.sv
module bat_store #(
   parameter int N  = 8,
   parameter int NI = 4,
   parameter int AW = 32,
   parameter int IW = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IW-1:0]         wr_idx,
   input  logic                  wr_hi,
   input  logic [AW-1:0]         wr_data,
   input  logic [IW-1:0]         rd_idx,
   input  logic                  rd_hi,
   output logic [AW-1:0]         rd_data,
   output logic [N-1:0][AW-1:0]  up_q,
   output logic [N-1:0][AW-1:0]  lo_q
);
   import bat_pkg::*;

   logic [AW-1:0] lo_wdata;

   always_comb begin
      lo_wdata = wr_data;
      if (32'(wr_idx) < NI) lo_wdata[GUARD_BIT] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         up_q <= '0;
         lo_q <= '0;
      end else if (wr_en && (32'(wr_idx) < N)) begin
         if (wr_hi) up_q[wr_idx] <= wr_data;
         else       lo_q[wr_idx] <= lo_wdata;
      end
   end

   always_comb begin
      rd_data = '0;
      if (32'(rd_idx) < N) rd_data = rd_hi ? up_q[rd_idx] : lo_q[rd_idx];
   end
endmodule

// File: rtl/bat_match.sv
module bat_match #(
   parameter int N     = 8,
   parameter int NI    = 4,
   parameter int AW    = 32,
   parameter int BLK_W = 15,
   parameter int MSK_W = 11
) (
   input  logic [N-1:0][AW-1:0] up_q,
   input  logic [N-1:0][AW-1:0] lo_q,
   input  logic [AW-1:0]        ea,
   input  logic                 is_inst,
   input  logic                 sup,
   output logic [N-1:0]         hit_vec,
   output logic [N-1:0][AW-1:0] pa_vec
);
   localparam int OFF_W = AW - BLK_W;

   for (genvar g = 0; g < N; g++) begin : g_ent
      localparam bit INST_SIDE = (g < NI);
      logic [BLK_W-1:0] care;
      logic             priv_ok;
      logic             tag_eq;

      assign care    = ~{{(BLK_W-MSK_W){1'b0}}, up_q[g][MSK_W+1:2]};
      assign priv_ok = sup ? up_q[g][1] : up_q[g][0];
      assign tag_eq  = (((ea[AW-1:OFF_W] ^ up_q[g][AW-1:OFF_W]) & care) == '0);
      assign hit_vec[g] = (is_inst == INST_SIDE) && priv_ok && tag_eq;
      assign pa_vec[g]  = {(lo_q[g][AW-1:OFF_W] & care) | (ea[AW-1:OFF_W] & ~care),
                           ea[OFF_W-1:0]};
   end
endmodule

// File: rtl/bat_pick.sv
module bat_pick #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  hit_vec,
   output logic          any_hit,
   output logic [IW-1:0] sel
);
   always_comb begin
      any_hit = 1'b0;
      sel     = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            any_hit = 1'b1;
            sel     = IW'(i);
         end
      end
   end
endmodule

// File: rtl/bat_array.sv
module bat_array #(
   parameter int N_PER_SIDE = 4,
   parameter int AW         = 32,
   parameter int BLK_W      = 15,
   parameter int MSK_W      = 11
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [$clog2(2*N_PER_SIDE)-1:0] wr_idx,
   input  logic                     wr_hi,
   input  logic [AW-1:0]            wr_data,
   input  logic [$clog2(2*N_PER_SIDE)-1:0] rd_idx,
   input  logic                     rd_hi,
   output logic [AW-1:0]            rd_data,
   input  logic                     lk_valid,
   input  logic [AW-1:0]            lk_ea,
   input  logic                     lk_inst,
   input  logic                     lk_sup,
   input  logic                     lk_write,
   output logic                     res_valid,
   output logic                     res_hit,
   output logic [AW-1:0]            res_pa,
   output logic [bat_pkg::ATTR_W-1:0] res_attr,
   output logic                     res_fault
);
   import bat_pkg::*;

   localparam int N     = 2 * N_PER_SIDE;
   localparam int IW    = $clog2(N);
   localparam int OFF_W = AW - BLK_W;

   if (N_PER_SIDE < 1) begin : g_bad_n
      $error("N_PER_SIDE must be at least 1");
   end
   if (MSK_W >= BLK_W) begin : g_bad_msk
      $error("length mask must be narrower than block index");
   end
   if (MSK_W + 2 > OFF_W) begin : g_bad_layout
      $error("mask and valid bits overlap the block index");
   end

   logic [N-1:0][AW-1:0] up_q;
   logic [N-1:0][AW-1:0] lo_q;
   logic [N-1:0]         hit_vec;
   logic [N-1:0][AW-1:0] pa_vec;
   logic                 any_hit;
   logic [IW-1:0]        sel;
   logic [AW-1:0]        sel_lo;

   bat_store #(.N(N), .NI(N_PER_SIDE), .AW(AW), .IW(IW)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_hi(wr_hi),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_hi(rd_hi), .rd_data(rd_data),
      .up_q(up_q), .lo_q(lo_q)
   );

   bat_match #(.N(N), .NI(N_PER_SIDE), .AW(AW), .BLK_W(BLK_W), .MSK_W(MSK_W)) u_match (
      .up_q(up_q), .lo_q(lo_q), .ea(lk_ea), .is_inst(lk_inst), .sup(lk_sup),
      .hit_vec(hit_vec), .pa_vec(pa_vec)
   );

   bat_pick #(.N(N), .IW(IW)) u_pick (
      .hit_vec(hit_vec), .any_hit(any_hit), .sel(sel)
   );

   assign sel_lo = lo_q[sel];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_pa    <= '0;
         res_attr  <= '0;
         res_fault <= 1'b0;
      end else begin
         res_valid <= lk_valid;
         res_hit   <= lk_valid && any_hit;
         res_pa    <= (lk_valid && any_hit) ? pa_vec[sel] : '0;
         res_attr  <= (lk_valid && any_hit) ? sel_lo[ATTR_LSB +: ATTR_W] : '0;
         res_fault <= lk_valid && any_hit && prot_violation(sel_lo[PROT_W-1:0], lk_write);
      end
   end
endmodule

// File: rtl/bat_array_chk.sv
module bat_array_chk #(
   parameter int N_PER_SIDE = 4,
   parameter int AW         = 32,
   parameter int IW         = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic [IW-1:0] rd_idx,
   input logic          rd_hi,
   input logic [AW-1:0] rd_data,
   input logic          lk_valid,
   input logic [AW-1:0] lk_ea,
   input logic          lk_inst,
   input logic          res_valid,
   input logic          res_hit,
   input logic [AW-1:0] res_pa,
   input logic [3:0]    res_attr,
   input logic          res_fault
);
   // R10
   req_to_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid);
   // R10
   idle_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !res_valid);
   // R8
   fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_fault |-> res_hit);
   // R9
   miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_hit |-> (res_pa == '0 && res_attr == '0 && !res_fault));
   // R4
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (!res_hit || res_pa[16:0] == $past(lk_ea[16:0])));
   // R2
   inst_guard_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(rd_idx) < N_PER_SIDE && !rd_hi) |-> !rd_data[3]);
   // R2
   inst_guard_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_inst) |=> !res_attr[0]);
endmodule

bind bat_array bat_array_chk #(.N_PER_SIDE(N_PER_SIDE), .AW(AW), .IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_hi(rd_hi), .rd_data(rd_data),
   .lk_valid(lk_valid), .lk_ea(lk_ea), .lk_inst(lk_inst), .res_valid(res_valid),
   .res_hit(res_hit), .res_pa(res_pa), .res_attr(res_attr), .res_fault(res_fault)
);

// File: tb/tb_bat_array.sv
`timescale 1ns/1ps
module tb_bat_array;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic        wr_hi = 1'b0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_idx = '0;
   logic        rd_hi = 1'b0;
   logic [31:0] rd_data;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_ea = '0;
   logic        lk_inst = 1'b0;
   logic        lk_sup = 1'b1;
   logic        lk_write = 1'b0;
   logic        res_valid, res_hit, res_fault;
   logic [31:0] res_pa;
   logic [3:0]  res_attr;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   string cur = "R1";

   bat_array dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_hi(wr_hi),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_hi(rd_hi), .rd_data(rd_data),
      .lk_valid(lk_valid), .lk_ea(lk_ea), .lk_inst(lk_inst), .lk_sup(lk_sup),
      .lk_write(lk_write), .res_valid(res_valid), .res_hit(res_hit),
      .res_pa(res_pa), .res_attr(res_attr), .res_fault(res_fault)
   );

   always #2.5 clk = ~clk;

   // Behavioural reference model
   logic [31:0] m_up [8];
   logic [31:0] m_lo [8];
   logic        e_valid, e_hit, e_fault;
   logic [31:0] e_pa;
   logic [3:0]  e_attr;

   always @(posedge clk) begin
      logic        h, f;
      logic [31:0] pa;
      logic [3:0]  at;
      h = 0; f = 0; pa = 0; at = 0;
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) begin m_up[i] <= 0; m_lo[i] <= 0; end
         e_valid <= 0; e_hit <= 0; e_fault <= 0; e_pa <= 0; e_attr <= 0;
      end else begin
         if (lk_valid) begin
            for (int i = (lk_inst ? 0 : 4); i < (lk_inst ? 4 : 8); i++) begin
               logic [14:0] care;
               logic        ok;
               care = ~{4'b0, m_up[i][12:2]};
               ok   = lk_sup ? m_up[i][1] : m_up[i][0];
               if (!h && ok && (((lk_ea[31:17] ^ m_up[i][31:17]) & care) == 0)) begin
                  h  = 1;
                  pa = {(m_lo[i][31:17] & care) | (lk_ea[31:17] & ~care), lk_ea[16:0]};
                  at = m_lo[i][6:3];
                  if (lk_write) f = (m_lo[i][1:0] != 2'b10);
                  else          f = (m_lo[i][1:0] == 2'b00);
               end
            end
         end
         e_valid <= lk_valid; e_hit <= h; e_pa <= pa; e_attr <= at; e_fault <= f;
         if (wr_en) begin
            if (wr_hi) m_up[wr_idx] <= wr_data;
            else m_lo[wr_idx] <= (wr_idx < 4) ? (wr_data & ~32'h8) : wr_data;
         end
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", cur, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R1 rd_data", rd_data, rd_hi ? m_up[rd_idx] : m_lo[rd_idx]);
         chk("R10 res_valid", 32'(res_valid), 32'(e_valid));
         chk("R3 res_hit", 32'(res_hit), 32'(e_hit));
         chk("R4 res_pa", res_pa, e_pa);
         chk("R9 res_attr", 32'(res_attr), 32'(e_attr));
         chk("R8 res_fault", 32'(res_fault), 32'(e_fault));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic logic [31:0] mk_up(input logic [14:0] epi, input logic [10:0] msk,
                                         input logic sv, input logic uv);
      return {epi, 4'b0, msk, sv, uv};
   endfunction

   function automatic logic [31:0] mk_lo(input logic [14:0] ppi, input logic [3:0] at,
                                         input logic [1:0] pr);
      return {ppi, 10'b0, at, 1'b0, pr};
   endfunction

   task automatic tick;
      @(posedge clk); #1;
      wr_en = 0; lk_valid = 0;
   endtask

   task automatic wr(input int idx, input logic hi, input logic [31:0] d);
      tick; wr_en = 1; wr_idx = 3'(idx); wr_hi = hi; wr_data = d;
   endtask

   task automatic rd(input int idx, input logic hi);
      tick; rd_idx = 3'(idx); rd_hi = hi;
   endtask

   task automatic lk(input logic [31:0] ea, input logic inst, input logic sup, input logic w);
      tick; lk_valid = 1; lk_ea = ea; lk_inst = inst; lk_sup = sup; lk_write = w;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      // R1: reset state then write/read of both words
      cur = "R1";
      rd(5, 1); rd(5, 0); rd(0, 1);
      wr(5, 1, 32'hDEAD_BEEF); wr(5, 0, 32'h1234_5678); wr(0, 1, 32'hA5A5_0003);
      rd(5, 1); rd(5, 0); rd(0, 1);
      // R2: guarded bit forced low on instruction side, kept on data side
      cur = "R2";
      wr(2, 0, mk_lo(15'h0100, 4'b1111, 2'b10)); rd(2, 0);
      wr(6, 0, mk_lo(15'h0100, 4'b1111, 2'b10)); rd(6, 0);
      wr(2, 1, mk_up(15'h0100, 11'h0, 1, 1));
      lk(32'h0200_0000, 1, 1, 0); tick; tick;
      // clear earlier entries
      for (int i = 0; i < 8; i++) begin wr(i, 1, 0); wr(i, 0, 0); end
      // R3: 128 KB block
      cur = "R3";
      wr(4, 1, mk_up(15'h0010, 11'h000, 1, 1));
      wr(4, 0, mk_lo(15'h0200, 4'b0010, 2'b10));
      lk(32'h0020_1234, 0, 1, 0); lk(32'h0022_0000, 0, 1, 0); lk(32'h0021_FFFF, 0, 0, 0);
      // R3: 256 MB block
      wr(6, 1, mk_up(15'h4000, 11'h7FF, 1, 1));
      wr(6, 0, mk_lo(15'h6000, 4'b0100, 2'b10));
      lk(32'h8ABC_DEF0, 0, 1, 0); lk(32'h9000_0000, 0, 1, 0); lk(32'h8FFF_FFFF, 0, 1, 0);
      // R4: mid-size mask merges address bits
      cur = "R4";
      wr(7, 1, mk_up(15'h0A00, 11'h00F, 1, 1));
      wr(7, 0, mk_lo(15'h7F00, 4'b1000, 2'b10));
      lk(32'h141E_5432, 0, 1, 0); lk(32'h1400_0001, 0, 1, 0); lk(32'h1420_0000, 0, 1, 0);
      // R5: privilege split
      cur = "R5";
      wr(5, 1, mk_up(15'h0300, 11'h0, 1, 0));
      wr(5, 0, mk_lo(15'h0301, 4'b0001, 2'b10));
      lk(32'h0600_0010, 0, 1, 0); lk(32'h0600_0010, 0, 0, 0);
      wr(5, 1, mk_up(15'h0300, 11'h0, 0, 1));
      lk(32'h0600_0010, 0, 1, 0); lk(32'h0600_0010, 0, 0, 0);
      // R6: side select
      cur = "R6";
      lk(32'h0020_1234, 1, 1, 0);
      wr(1, 1, mk_up(15'h0010, 11'h0, 1, 1));
      wr(1, 0, mk_lo(15'h0055, 4'b1111, 2'b01));
      lk(32'h0020_1234, 1, 1, 0); lk(32'h0020_1234, 0, 1, 0);
      // R7: overlapping entries, lowest wins
      cur = "R7";
      wr(5, 1, mk_up(15'h0010, 11'h0, 1, 1));
      wr(5, 0, mk_lo(15'h0777, 4'b0011, 2'b00));
      lk(32'h0020_0040, 0, 1, 0);
      wr(4, 1, 0);
      lk(32'h0020_0040, 0, 1, 0);
      // R8: every protection code against read and write
      cur = "R8";
      for (int p = 0; p < 4; p++) begin
         wr(5, 0, mk_lo(15'h0777, 4'b0000, 2'(p)));
         lk(32'h0020_0040, 0, 1, 0); lk(32'h0020_0040, 0, 1, 1);
      end
      // R9: miss after hit, attributes zero
      cur = "R9";
      lk(32'h0020_0040, 0, 1, 0); lk(32'hFFFF_0000, 0, 1, 1); tick;
      // R10: lookup and write in the same cycle use old contents
      cur = "R10";
      tick; lk_valid = 1; lk_ea = 32'h0020_0040; lk_inst = 0; lk_sup = 1; lk_write = 0;
      wr_en = 1; wr_idx = 5; wr_hi = 1; wr_data = 0;
      lk(32'h0020_0040, 0, 1, 0);
      tick; tick; tick;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule